// File: doc/BRIEF.md
# Indirect Peripheral Clock Control Register

This block holds the clock settings of a bank of peripherals behind a single 32-bit control word. Every access names one peripheral by its identifier and carries a command bit: a write-mode access stores that peripheral's enable and divisor, and a read-mode access only points the readback at it. The register then returns the chosen identifier together with the enable and divisor stored for it. Identifiers 0 and 1 have no settings, and accesses that name them are ignored.

Only two identifiers, set by parameter, may run from a divided clock. All the others are held at full rate. A divisor cannot be changed while the peripheral's clock runs. To change it, software first disables the clock with the divisor unchanged, then writes the new divisor, then enables the clock again. A write that breaks this rule keeps the old divisor and sets a sticky error flag. For every peripheral the block produces a registered clock enable, its divisor selection, and a clock-enable tick at full rate, half rate or quarter rate. A downstream gating cell uses these outputs.

Top module: `pcc_ctrl`

## Requirements
- R1: A write-mode access (wr_en high, bit 12 = 1) to identifier 2..63 stores enable (bit 28) and the legal divisor (bits 17:16) for that identifier. The new values appear on clk_en_o and div_sel_o after the next rising clock edge.
- R2: A read-mode access (bit 12 = 0) changes no clk_en_o or div_sel_o bit. It only makes the addressed identifier the readback selection.
- R3: An access of either mode to identifier 0 or 1 changes no state, including the readback selection. clk_en_o[1:0] stays 0.
- R4: rd_data returns the selected identifier in bits 5:0, its divisor in bits 17:16 and its enable in bit 28. All other bits, including the command bit 12, read 0. Any accepted access of either mode sets the selection.
- R5: Divisor codes are 0 = full rate, 1 = half rate, 2 = quarter rate. Code 3 is stored as 0. Identifiers other than DIV_ID_A and DIV_ID_B always store 0.
- R6: A write to an enabled peripheral whose legal divisor differs from the stored one keeps the stored divisor. The enable field of that write still applies.
- R7: Such a write sets div_err_o, which stays high until reset.
- R8: After reset, all enables, divisors, the selection and div_err_o are 0.
- R9: For a divisible peripheral the tick is high in the first enabled cycle and then once every 1, 2 or 4 cycles for divisor 0, 1 or 2. While the peripheral is disabled the tick is low.
- R10: A peripheral without division support ticks in every enabled cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Access strobe for the control word |
| wr_data | input | 32 | Control word: identifier, command, divisor, enable |
| rd_data | output | 32 | Readback of the selected peripheral |
| clk_en_o | output | N_PERIPH | Per-peripheral clock enable |
| div_sel_o | output | 2*N_PERIPH | Per-peripheral divisor code, 2 bits each |
| tick_o | output | N_PERIPH | Per-peripheral clock-enable tick |
| div_err_o | output | 1 | Sticky divisor-lock violation flag |

## Verification
The bench uses the default build: 64 identifiers, with division allowed on identifiers 40 and 41. A write sweep and a read sweep over all 64 identifiers cover the ignored low identifiers, the non-divisible peripherals that must clamp their divisor, and the two divisible ones. Because this build has two divisible identifiers, the bench can exercise the lock violation, the three-step divisor change, the reserved code and all three tick rates, and count the ticks over a window of eight cycles.

// File: rtl/pcc_pkg.sv
package pcc_pkg;
    localparam int REG_W    = 32;
    localparam int ID_LSB   = 0;
    localparam int CMD_POS  = 12;
    localparam int DIV_LSB  = 16;
    localparam int DIV_W    = 2;
    localparam int EN_POS   = 28;
    localparam int FIRST_ID = 2;

    typedef enum logic [1:0] {
        RATE_FULL    = 2'd0,
        RATE_HALF    = 2'd1,
        RATE_QUARTER = 2'd2,
        RATE_RSVD    = 2'd3
    } rate_e;
endpackage

// File: rtl/pcc_decode.sv
module pcc_decode
    import pcc_pkg::*;
#(
    parameter int N_PERIPH = 64,
    parameter int DIV_ID_A = 40,
    parameter int DIV_ID_B = 41,
    localparam int ID_W = $clog2(N_PERIPH)
) (
    input  logic [REG_W-1:0] wr_data,
    output logic [ID_W-1:0]  id,
    output logic             valid,
    output logic             cmd_wr,
    output logic             en,
    output logic [DIV_W-1:0] div
);
    logic [DIV_W-1:0] raw_div;
    logic             divisible;
    logic             unused_wr;

    assign unused_wr = ^wr_data;

    always_comb begin
        id        = wr_data[ID_LSB +: ID_W];
        valid     = (int'(id) >= FIRST_ID) && (int'(id) < N_PERIPH);
        cmd_wr    = wr_data[CMD_POS];
        en        = wr_data[EN_POS];
        raw_div   = wr_data[DIV_LSB +: DIV_W];
        divisible = (int'(id) == DIV_ID_A) || (int'(id) == DIV_ID_B);
        if (!divisible || raw_div == RATE_RSVD) begin
            div = RATE_FULL;
        end else begin
            div = raw_div;
        end
    end
endmodule

// File: rtl/pcc_readback.sv
module pcc_readback
    import pcc_pkg::*;
#(
    parameter int N_PERIPH = 64,
    localparam int ID_W = $clog2(N_PERIPH)
) (
    input  logic [ID_W-1:0]                 sel,
    input  logic [N_PERIPH-1:0]             en_vec,
    input  logic [N_PERIPH-1:0][DIV_W-1:0]  div_vec,
    output logic [REG_W-1:0]                rd_data
);
    always_comb begin
        rd_data                       = '0;
        rd_data[ID_LSB +: ID_W]       = sel;
        rd_data[DIV_LSB +: DIV_W]     = div_vec[sel];
        rd_data[EN_POS]               = en_vec[sel];
    end
endmodule

// File: rtl/pcc_divgen.sv
module pcc_divgen
    import pcc_pkg::*;
#(
    parameter bit DIVISIBLE = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    generate
        if (DIVISIBLE) begin : g_div
            logic [1:0] cnt_d, cnt_q;

            always_comb begin
                cnt_d = en ? cnt_q + 2'd1 : 2'd0;
                case (rate_e'(div))
                    RATE_HALF:    tick = en & ~cnt_q[0];
                    RATE_QUARTER: tick = en & (cnt_q == 2'd0);
                    default:      tick = en;
                endcase
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) cnt_q <= '0;
                else        cnt_q <= cnt_d;
            end
        end else begin : g_full
            logic unused_in;
            assign unused_in = &{1'b0, clk, rst_n, div};
            assign tick = en;
        end
    endgenerate
endmodule

// File: rtl/pcc_ctrl.sv
module pcc_ctrl
    import pcc_pkg::*;
#(
    parameter int N_PERIPH = 64,
    parameter int DIV_ID_A = 40,
    parameter int DIV_ID_B = 41,
    localparam int ID_W = $clog2(N_PERIPH)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [REG_W-1:0]            wr_data,
    output logic [REG_W-1:0]            rd_data,
    output logic [N_PERIPH-1:0]         clk_en_o,
    output logic [2*N_PERIPH-1:0]       div_sel_o,
    output logic [N_PERIPH-1:0]         tick_o,
    output logic                        div_err_o
);
    typedef struct packed {
        logic [ID_W-1:0]                sel;
        logic [N_PERIPH-1:0]            en;
        logic [N_PERIPH-1:0][DIV_W-1:0] div;
        logic                           err;
    } state_t;

    state_t st_d, st_q;

    logic [ID_W-1:0]  acc_id;
    logic             acc_valid;
    logic             acc_wr;
    logic             acc_en;
    logic [DIV_W-1:0] acc_div;

    pcc_decode #(
        .N_PERIPH (N_PERIPH),
        .DIV_ID_A (DIV_ID_A),
        .DIV_ID_B (DIV_ID_B)
    ) u_decode (
        .wr_data (wr_data),
        .id      (acc_id),
        .valid   (acc_valid),
        .cmd_wr  (acc_wr),
        .en      (acc_en),
        .div     (acc_div)
    );

    // next-state: selection, per-peripheral table, sticky lock error
    always_comb begin
        st_d = st_q;
        if (wr_en && acc_valid) begin
            st_d.sel = acc_id;
            if (acc_wr) begin
                st_d.en[acc_id] = acc_en;
                if (st_q.en[acc_id] && (acc_div != st_q.div[acc_id])) begin
                    st_d.err = 1'b1;
                end else begin
                    st_d.div[acc_id] = acc_div;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    pcc_readback #(
        .N_PERIPH (N_PERIPH)
    ) u_readback (
        .sel     (st_q.sel),
        .en_vec  (st_q.en),
        .div_vec (st_q.div),
        .rd_data (rd_data)
    );

    genvar gi;
    generate
        for (gi = 0; gi < N_PERIPH; gi++) begin : g_tick
            pcc_divgen #(
                .DIVISIBLE ((gi == DIV_ID_A) || (gi == DIV_ID_B))
            ) u_divgen (
                .clk   (clk),
                .rst_n (rst_n),
                .en    (st_q.en[gi]),
                .div   (st_q.div[gi]),
                .tick  (tick_o[gi])
            );
        end
    endgenerate

    assign clk_en_o  = st_q.en;
    assign div_sel_o = st_q.div;
    assign div_err_o = st_q.err;
endmodule

// File: rtl/pcc_ctrl_checker.sv
module pcc_ctrl_checker
    import pcc_pkg::*;
#(
    parameter int N_PERIPH = 64,
    parameter int DIV_ID_A = 40,
    parameter int DIV_ID_B = 41
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  wr_en,
    input logic [REG_W-1:0]      wr_data,
    input logic [REG_W-1:0]      rd_data,
    input logic [N_PERIPH-1:0]   clk_en_o,
    input logic [2*N_PERIPH-1:0] div_sel_o,
    input logic [N_PERIPH-1:0]   tick_o,
    input logic                  div_err_o
);
    p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        div_err_o |=> div_err_o);

    p_read_keeps_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[CMD_POS]) |=> ($stable(clk_en_o) && $stable(div_sel_o)));

    p_low_ids_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en_o[1:0] == 2'b00);

    p_cmd_reads_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[CMD_POS]);

    p_tick_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o & ~clk_en_o) == '0);

    genvar gi;
    generate
        for (gi = 0; gi < N_PERIPH; gi++) begin : g_per
            p_div_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
                clk_en_o[gi] |=> $stable(div_sel_o[2*gi +: 2]));

            p_no_rsvd_r5: assert property (@(posedge clk) disable iff (!rst_n)
                div_sel_o[2*gi +: 2] != 2'd3);

            if ((gi != DIV_ID_A) && (gi != DIV_ID_B)) begin : g_nodiv
                p_full_rate_r5: assert property (@(posedge clk) disable iff (!rst_n)
                    div_sel_o[2*gi +: 2] == 2'd0);
                p_tick_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
                    tick_o[gi] == clk_en_o[gi]);
            end
        end
    endgenerate
endmodule

bind pcc_ctrl pcc_ctrl_checker #(
    .N_PERIPH (N_PERIPH),
    .DIV_ID_A (DIV_ID_A),
    .DIV_ID_B (DIV_ID_B)
) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .clk_en_o  (clk_en_o),
    .div_sel_o (div_sel_o),
    .tick_o    (tick_o),
    .div_err_o (div_err_o)
);

// File: tb/pcc_ctrl_test.sv
module pcc_ctrl_test;
    localparam int N  = 64;
    localparam int DA = 40;
    localparam int DB = 41;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wr_en = 1'b0;
    logic [31:0]     wr_data = '0;
    logic [31:0]     rd_data;
    logic [N-1:0]    clk_en_o;
    logic [2*N-1:0]  div_sel_o;
    logic [N-1:0]    tick_o;
    logic            div_err_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pcc_ctrl #(.N_PERIPH(N), .DIV_ID_A(DA), .DIV_ID_B(DB)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .clk_en_o  (clk_en_o),
        .div_sel_o (div_sel_o),
        .tick_o    (tick_o),
        .div_err_o (div_err_o)
    );

    function automatic logic [31:0] word(int id, bit wr, int dv, bit en);
        return 32'(id) | (32'(wr) << 12) | (32'(dv) << 16) | (32'(en) << 28);
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(logic [31:0] w);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = w;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = '0;
    endtask

    task automatic count_ticks(int id, int cycles, output int cnt);
        cnt = 0;
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            if (tick_o[id]) cnt++;
        end
    endtask

    initial begin
        int n;
        int dv;
        logic [31:0] last_rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R8 reset state
        chk("R8 rd", 64'(rd_data), 0);
        chk("R8 en", 64'(clk_en_o), 0);
        chk("R8 div lo", div_sel_o[63:0], 0);
        chk("R8 div hi", div_sel_o[127:64], 0);
        chk("R8 err", 64'(div_err_o), 0);

        // R1 R3 R4 R5 write sweep, divisor 1 requested everywhere
        last_rd = 32'h0;
        for (int id = 0; id < N; id++) begin
            access(word(id, 1'b1, 1, 1'b1));
            dv = (id == DA || id == DB) ? 1 : 0;
            if (id < 2) begin
                chk("R3 ignored en", 64'(clk_en_o[id]), 0);
                chk("R3 sel kept", 64'(rd_data), 64'(last_rd));
            end else begin
                chk("R1 en", 64'(clk_en_o[id]), 1);
                chk("R5 div", 64'(div_sel_o[2*id +: 2]), 64'(dv));
                last_rd = word(id, 1'b0, dv, 1'b1);
                chk("R4 rd", 64'(rd_data), 64'(last_rd));
            end
        end
        chk("R7 no err", 64'(div_err_o), 0);

        // R2 read sweep: requests disable, must change nothing
        for (int id = 2; id < N; id++) begin
            access(word(id, 1'b0, 2, 1'b0));
            dv = (id == DA || id == DB) ? 1 : 0;
            chk("R2 rd", 64'(rd_data), 64'(word(id, 1'b0, dv, 1'b1)));
        end
        chk("R2 en all", 64'(clk_en_o), {{62{1'b1}}, 2'b00});
        access(word(1, 1'b0, 0, 1'b0));
        chk("R3 read low id", 64'(rd_data), 64'(word(N-1, 1'b0, 0, 1'b1)));

        // R6 R7 change while enabled
        access(word(DA, 1'b1, 2, 1'b1));
        chk("R6 div kept", 64'(div_sel_o[2*DA +: 2]), 1);
        chk("R6 en", 64'(clk_en_o[DA]), 1);
        chk("R7 err set", 64'(div_err_o), 1);

        // R6 legal three-step change
        access(word(DA, 1'b1, 1, 1'b0));
        access(word(DA, 1'b1, 2, 1'b0));
        chk("R6 div after step2", 64'(div_sel_o[2*DA +: 2]), 2);
        access(word(DA, 1'b1, 2, 1'b1));
        chk("R6 en after step3", 64'(clk_en_o[DA]), 1);
        chk("R4 rd step3", 64'(rd_data), 64'(word(DA, 1'b0, 2, 1'b1)));

        // R6 disable with change: enable applies, divisor kept
        access(word(DB, 1'b1, 2, 1'b0));
        chk("R6 en off", 64'(clk_en_o[DB]), 0);
        chk("R6 div kept DB", 64'(div_sel_o[2*DB +: 2]), 1);
        chk("R7 sticky", 64'(div_err_o), 1);

        // R5 reserved code
        access(word(DB, 1'b1, 3, 1'b0));
        chk("R5 rsvd", 64'(div_sel_o[2*DB +: 2]), 0);

        // R4 R5 stray bits set and reserved request on non-divisible id
        access(32'hFFFF_FFC5);
        chk("R4 stray bits", 64'(rd_data), 64'(32'h1000_0005));

        // R9 R10 tick rates
        count_ticks(DA, 8, n);
        chk("R9 quarter", 64'(n), 2);
        access(word(DB, 1'b1, 1, 1'b1));
        chk("R9 first tick", 64'(tick_o[DB]), 1);
        count_ticks(DB, 8, n);
        chk("R9 half", 64'(n), 4);
        access(word(DB, 1'b1, 1, 1'b0));
        access(word(DB, 1'b1, 0, 1'b0));
        access(word(DB, 1'b1, 0, 1'b1));
        count_ticks(DB, 8, n);
        chk("R9 full", 64'(n), 8);
        count_ticks(10, 8, n);
        chk("R10 full rate", 64'(n), 8);
        access(word(10, 1'b1, 0, 1'b0));
        count_ticks(10, 8, n);
        chk("R9 disabled", 64'(n), 0);
        chk("R7 still set", 64'(div_err_o), 1);

        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 20000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule